// File: doc/BRIEF.md
# Selectable-Ratio Half-Band Interpolator

This block raises the sample rate of a 16-bit two's-complement stream by 1, 2, 4 or 8. Three fixed interpolate-by-two half-band stages sit in a chain. A two-bit rate code chooses how many of them are active, and the output is taken from the last active stage. Each stage is a two-phase polyphase filter that does its arithmetic once per input sample. One phase is a symmetric tap sum: sample pairs are added first, then weighted, rounded, shifted and saturated. The other phase is a delayed copy of the sample at the middle of the delay line. The stage emits the two phases alternately, which doubles the rate.

The whole chain runs on a single clock at the highest output rate. Samples enter with a valid strobe spaced 2^K clock cycles apart, where K is the rate code. A stage that is not in use gets no enable, so none of its registers change. Changing the rate code clears every delay line, so the first samples in the new mode start from zero history.

Top module: `hb_interp_chain`

## Requirements
- R1: `stage_active` reports which stages are enabled (bit 0 is the first stage): rate 00 gives 000, 01 gives 001, 10 gives 011 and 11 gives 111. It reads 000 after reset. A disabled stage holds its state and raises no output strobe.
- R2: With rate 00, every input sample appears unchanged on `out_data`, with `out_valid` high, one cycle after it is accepted.
- R3: With rate code K, each accepted input sample yields exactly 2^K output samples. Each stage emits its filtered phase first and its center phase second, and the stage output strobe comes two cycles after the stage input strobe.
- R4: Stage one keeps 22 samples d[0..21], where d[0] is the newest. Its filtered phase is the sum over i=0..10 of c[i]*(d[i]+d[21-i]), with c = 10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364. The sum is rounded by adding 2^13, arithmetically shifted right by 14, and saturated.
- R5: Stage two keeps 10 samples and uses 5 parameterised taps (default 18, -116, 424, -1260, 5030, outermost pair first). It rounds and shifts by 13.
- R6: Stage three keeps 4 samples and uses taps -136 (outer pair) and 1160 (inner pair). It rounds and shifts by 11.
- R7: The center phase of a stage with an N-sample delay line is d[N/2-1], taken from the same delay-line state as the filtered phase that precedes it.
- R8: A constant input at any 16-bit value, including -32768 and 32767, leaves the output equal to that value once the delay lines are full, in every mode.
- R9: Filtered phases that exceed the 16-bit range are clamped to 32767 or -32768.
- R10: A change of the rate code clears all delay lines and the output strobe in the same cycle, so the new mode's output starts from zero history.
- R11: In the x8 mode, with input strobes every 8 cycles, `out_valid` is high on every cycle from the first output sample to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the highest output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate | input | 2 | Interpolation code: 00 none, 01 x2, 10 x4, 11 x8 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample, two's complement |
| stage_active | output | 3 | Enable of each half-band stage |

## Verification
The assertions take two things for granted. Input strobes arrive exactly every 2^K cycles for the selected rate, and the rate code stays fixed while samples are still in flight. Within those limits each stage's output strobe must follow its input strobe after two cycles, and a stage whose enable is low must stay frozen. The bench derives every strobe from a fixed cycle count per mode. It lets the pipeline drain for many idle cycles before it moves the rate code, so a clear never cuts into a stream whose output is being compared.

// File: rtl/hb_interp_chain.sv
`timescale 1ns/1ps
module hb_interp_chain #(
  parameter int DW = 16,
  parameter int S2_TAPS [5] = '{18, -116, 424, -1260, 5030}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rate,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [2:0]           stage_active
);
  localparam int AW = DW + 24;
  localparam logic signed [AW-1:0] SMAX = AW'((1 << (DW-1)) - 1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

  function automatic int coef(int s, int i);
    if (s == 1) return S2_TAPS[i];
    if (s == 2) return (i == 0) ? -136 : 1160;
    case (i)
      0: return 10;      1: return -31;    2: return 69;
      3: return -138;    4: return 248;    5: return -419;
      6: return 678;     7: return -1083;  8: return 1776;
      9: return -3282;   default: return 10364;
    endcase
  endfunction

  logic [1:0] rate_q;
  logic       clr;
  assign clr = rate != rate_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rate_q <= '0;
    else        rate_q <= rate;

  assign stage_active = (rate_q == 2'd0) ? 3'b000 :
                        (rate_q == 2'd1) ? 3'b001 :
                        (rate_q == 2'd2) ? 3'b011 : 3'b111;

  logic [3:0][DW-1:0] sd;
  logic [3:0]         sv;
  assign sd[0] = in_data;
  assign sv[0] = in_valid;

  for (genvar g = 0; g < 3; g++) begin : g_stage
    localparam int N  = (g == 0) ? 22 : (g == 1) ? 10 : 4;
    localparam int M  = N / 2;
    localparam int SH = (g == 0) ? 14 : (g == 1) ? 13 : 11;

    logic                 en, v_in, v1, ov, sec;
    logic [3:0]           vdl;
    logic signed [DW-1:0] dl [N];
    logic signed [DW-1:0] ctr, od, sat;
    logic signed [AW-1:0] acc, rnd;

    assign en   = stage_active[g];
    assign v_in = sv[g] & en & ~clr;
    assign sec  = (int'(rate_q) - g == 1) ? vdl[0] :
                  (int'(rate_q) - g == 2) ? vdl[1] :
                  (int'(rate_q) - g == 3) ? vdl[3] : 1'b0;

    always_comb begin
      acc = '0;
      for (int i = 0; i < M; i++)
        acc += AW'(coef(g, i)) * (AW'(dl[i]) + AW'(dl[N-1-i]));
      rnd = (acc + (AW'(1) <<< (SH-1))) >>> SH;
      sat = (rnd > SMAX) ? SMAX[DW-1:0] : (rnd < SMIN) ? SMIN[DW-1:0] : rnd[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        v1 <= 1'b0; vdl <= '0; ov <= 1'b0; od <= '0; ctr <= '0;
        for (int i = 0; i < N; i++) dl[i] <= '0;
      end else if (clr) begin
        v1 <= 1'b0; vdl <= '0; ov <= 1'b0; od <= '0; ctr <= '0;
        for (int i = 0; i < N; i++) dl[i] <= '0;
      end else begin
        v1  <= v_in;
        vdl <= {vdl[2:0], v1};
        ov  <= v1 | sec;
        if (v_in) begin
          dl[0] <= sd[g];
          for (int i = 1; i < N; i++) dl[i] <= dl[i-1];
        end
        if (v1) begin
          od  <= sat;
          ctr <= dl[M-1];
        end else if (sec) begin
          od <= ctr;
        end
      end

    assign sd[g+1] = od;
    assign sv[g+1] = ov;

    assert_gated_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !en |=> $stable(dl[0]));
    assert_gated_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !en |=> !ov);
    assert_stage_latency_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      v_in |=> ##1 ov);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= sv[rate_q] & ~clr;
      out_data  <= sd[rate_q];
    end

  assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'd0 && !clr && in_valid) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/hb_interp_chain_tb.sv
`timescale 1ns/1ps
module hb_interp_chain_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rate = 2'd0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;
  logic [2:0] stage_active;

  always #2.5 clk = ~clk;

  hb_interp_chain u_dut (
    .clk(clk), .rst_n(rst_n), .rate(rate), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .stage_active(stage_active)
  );

  int T1 [11] = '{10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364};
  int T2 [5]  = '{18, -116, 424, -1260, 5030};
  int T3 [2]  = '{-136, 1160};

  int checks = 0, failures = 0;
  int xa [1024], xb [1024], inp [1024], expv [1024];
  int nx, nexp, got, cur_k, last_out;
  bit cap = 0, sat_hi = 0, done = 0;
  string tag = "R2";
  longint cyc = 0, first_c = 0, last_c = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(bit ok, string t, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  function automatic int tap(int s, int i);
    if (s == 0) return T1[i];
    if (s == 1) return T2[i];
    return T3[i];
  endfunction

  function automatic int xv(int idx);
    return (idx < 0) ? 0 : xa[idx];
  endfunction

  task automatic run_stage(int s);
    int len = (s == 0) ? 22 : (s == 1) ? 10 : 4;
    int sh  = (s == 0) ? 14 : (s == 1) ? 13 : 11;
    for (int n = 0; n < nx; n++) begin
      longint acc = 0;
      for (int i = 0; i < len / 2; i++)
        acc += longint'(tap(s, i)) * (longint'(xv(n - i)) + longint'(xv(n - (len - 1 - i))));
      acc = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      xb[2*n]   = int'(acc);
      xb[2*n+1] = xv(n - (len / 2 - 1));
    end
    nx = nx * 2;
    for (int i = 0; i < nx; i++) xa[i] = xb[i];
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cap && out_valid) begin
      if (got < nexp)
        chk(out_data == expv[got], (cur_k > 0 && got % 2 == 1) ? "R7" : tag, out_data, expv[got]);
      if (got == 0) first_c = cyc;
      last_c = cyc;
      last_out = out_data;
      if (out_data == 16'sd32767) sat_hi = 1;
      got++;
    end
  end

  task automatic run_case(int k, int nin, int kind, string t, int dcv);
    int p = 1 << k;
    for (int n = 0; n < nin; n++) begin
      int v;
      if (kind == 0) v = dcv;
      else if (kind == 1) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = int'($signed(seed[15:0]));
      end else begin
        int j = 21 - n;
        int mm = (j < 21 - j) ? j : 21 - j;
        v = (n < 22) ? ((mm % 2 == 0) ? 32767 : -32767) : 0;
      end
      inp[n] = v;
      xa[n]  = v;
    end
    nx = nin;
    for (int s = 0; s < k; s++) run_stage(s);
    for (int i = 0; i < nx; i++) expv[i] = xa[i];
    nexp = nx;
    rate = 2'(k);
    repeat (4) @(negedge clk);
    chk(stage_active == ((k == 0) ? 3'b000 : (k == 1) ? 3'b001 : (k == 2) ? 3'b011 : 3'b111),
        "R1", stage_active, k);
    got = 0; cur_k = k; tag = t; cap = 1;
    for (int n = 0; n < nin; n++) begin
      in_valid = 1'b1;
      in_data  = 16'(inp[n]);
      @(negedge clk);
      if (p > 1) begin
        in_valid = 1'b0;
        repeat (p - 1) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (80) @(negedge clk);
    cap = 0;
    chk(got == nexp, "R3", got, nexp);
    if (k == 3) chk(last_c - first_c + 1 == longint'(got), "R11", last_c - first_c + 1, got);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog expired act=0 exp=1");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(stage_active == 3'b000, "R1", stage_active, 0);

    run_case(0, 40, 1, "R2", 0);
    run_case(1, 60, 1, "R4", 0);
    run_case(2, 40, 1, "R5", 0);
    run_case(3, 30, 1, "R6", 0);
    run_case(1, 34, 2, "R10", 0);
    chk(sat_hi, "R9", sat_hi, 1);
    run_case(2, 40, 0, "R8", 32767);
    chk(last_out == 32767, "R8", last_out, 32767);
    run_case(3, 40, 0, "R8", -32768);
    chk(last_out == -32768, "R8", last_out, -32768);
    run_case(1, 40, 0, "R8", 1234);
    chk(last_out == 1234, "R8", last_out, 1234);
    run_case(0, 10, 0, "R2", -5);
    finish_up();
  end
endmodule